// File: doc/BRIEF.md
# Interrupt-Entry Process ID Tracker

This block sits beside a CPU's instruction-fetch path and keeps the identity of the running process. It compares every valid instruction fetch against seven programmable vector entry addresses, one for each interrupt priority level. When a fetch lands on the entry address of a level whose enable bit is set, the block takes the CPU into process 0, makes that level the current interrupt level and saves the previous level and process in a context register that belongs to the new level. Software can later use that saved context to unwind nested interrupts.

Process IDs run from 0 to 7. Processes 0 and 1 are the privileged ones. Interrupt levels run from 1 to 7: levels 1 to 5 are ordinary, level 6 is for debug and level 7 is the non-maskable interrupt. A small word-addressed register bus gives software access to the enable mask, the vector addresses, the current level, the current process and the seven saved-context registers. A write to the process register switches the process at once. The delayed, software-timed switch is not part of this block.

Top module: `irq_pid_tracker`

## Requirements
- R1: After reset the current process is 0, the current level is 0, all seven saved-context registers read 0 and the enable register reads 0.
- R2: A fetch with `fetch_valid`=1 and `fetch_is_data`=0 whose address equals the vector of level L, while enable bit L is set, sets `cur_pid` to 0 and `cur_level` to L at the next clock edge. L is 1..7, with 7 meaning NMI and 0 meaning no interrupt.
- R3: At that same edge, saved-context register L takes bits [6:3] = the previous level (bit 6 always 0) and bits [2:0] = the previous process ID.
- R4: A fetch that matches the vector of a level whose enable bit is clear changes neither the process, the level nor any saved-context register.
- R5: An access with `fetch_is_data`=1 never triggers recognition, even when its address matches an enabled vector.
- R6: When several enabled vectors hold the fetched address, the highest level among them is recognised.
- R7: Register map (word index on `reg_addr`): 0x00 enable (bit N enables level N for N=1..7, bit 0 reads 0), 0x01..0x07 vector of levels 1..7, 0x08 current level [2:0], 0x09 current process [2:0], 0x11..0x17 saved context of levels 1..7 [6:0]. Writes take effect at the next edge. Reads are combinational and return 0 at unmapped indices.
- R8: When a recognition and a bus write fall in the same cycle, the recognition decides the process, the level and saved-context register L. A write to any other register in that cycle still takes effect. Recognition uses the vector values from before the write.
- R9: Successive recognitions nest. A second recognition saves the first interrupt's level together with process 0.
- R10: With `fetch_valid`=0 and no bus write, no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | CPU access strobe |
| fetch_is_data | input | 1 | 1 marks a data access, 0 an instruction fetch |
| fetch_addr | input | ADDR_W | Access address |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word index |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data (combinational) |
| cur_pid | output | 3 | Current process ID |
| cur_level | output | 3 | Current interrupt level |

## Verification
The two functions that can meet in one cycle are hardware recognition of an interrupt entry and a software write on the register bus. The bench provokes this collision on purpose. It writes the process register, the saved-context register of the level being entered, another level's saved-context register and a vector address, each in the same cycle as a matching fetch. Random cycles that pair a fetch with a write provoke it further. Each outcome is judged against a bench model. In that model, recognition owns the process, the level and context register L, and every other write lands. The model compares against vectors taken before the write.

// File: rtl/irq_pid_pkg.sv
// Shared widths, types and register indices for the interrupt-entry
// process ID tracker. Assumes 8 process IDs and 7 interrupt levels.
package irq_pid_pkg;
    localparam int PID_W    = 3;
    localparam int LVL_W    = 3;
    localparam int NUM_LVL  = (1 << LVL_W) - 1;
    localparam int HIST_W   = (LVL_W + 1) + PID_W;
    localparam int REG_AW   = 5;

    typedef logic [PID_W-1:0]  pid_t;
    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [HIST_W-1:0] hist_t;

    // Register word indices; vector L sits at index L, context L at CTX_BASE+L
    localparam logic [REG_AW-1:0] IDX_EN       = 5'h00;
    localparam logic [REG_AW-1:0] IDX_LEVEL    = 5'h08;
    localparam logic [REG_AW-1:0] IDX_PID      = 5'h09;
    localparam logic [REG_AW-1:0] IDX_CTX_BASE = 5'h10;
endpackage

// File: rtl/irq_pid_cfg.sv
// Configuration storage: the per-level enable mask and the per-level vector
// entry addresses. Assumes ADDR_W >= 8 so the enable mask fits in write data.
module irq_pid_cfg
    import irq_pid_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [REG_AW-1:0]         wr_idx,
    input  logic [ADDR_W-1:0]         wr_data,
    output logic [NUM_LVL:1]          lvl_enable,
    output logic [NUM_LVL*ADDR_W-1:0] vec_flat
);
    // Enable mask register: bit N of the write data enables level N
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_enable <= '0;
        end else if (wr_en && wr_idx == IDX_EN) begin
            lvl_enable <= wr_data[NUM_LVL:1];
        end
    end

    // One vector entry register per level, written at its own index
    for (genvar l = 1; l <= NUM_LVL; l++) begin : g_vec
        logic [ADDR_W-1:0] vec_q;

        // Hold the entry address of level l
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vec_q <= '0;
            end else if (wr_en && wr_idx == REG_AW'(l)) begin
                vec_q <= wr_data;
            end
        end

        assign vec_flat[(l-1)*ADDR_W +: ADDR_W] = vec_q;
    end
endmodule

// File: rtl/irq_pid_match.sv
// Interrupt entry detector: compares an instruction fetch against every
// enabled vector and reports the highest matching level. Purely
// combinational; data accesses never match.
module irq_pid_match
    import irq_pid_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                      fetch_valid,
    input  logic                      fetch_is_data,
    input  logic [ADDR_W-1:0]         fetch_addr,
    input  logic [NUM_LVL:1]          lvl_enable,
    input  logic [NUM_LVL*ADDR_W-1:0] vec_flat,
    output logic                      rec_valid,
    output lvl_t                      rec_lvl
);
    logic [NUM_LVL:1] hit;
    logic             is_ifetch;

    assign is_ifetch = fetch_valid && !fetch_is_data;

    // One address comparator per level
    for (genvar l = 1; l <= NUM_LVL; l++) begin : g_cmp
        assign hit[l] = is_ifetch && lvl_enable[l]
                        && (fetch_addr == vec_flat[(l-1)*ADDR_W +: ADDR_W]);
    end

    // Priority pick: a later (higher) level overrides a lower one
    always_comb begin
        rec_valid = 1'b0;
        rec_lvl   = '0;
        for (int l = 1; l <= NUM_LVL; l++) begin
            if (hit[l]) begin
                rec_valid = 1'b1;
                rec_lvl   = lvl_t'(l);
            end
        end
    end
endmodule

// File: rtl/irq_pid_ctx.sv
// Execution context state: current process, current level and the saved
// context of each level. A recognition takes precedence over a bus write to
// the same register; bus writes to other registers still land.
module irq_pid_ctx
    import irq_pid_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rec_valid,
    input  lvl_t                         rec_lvl,
    input  logic                         wr_en,
    input  logic [REG_AW-1:0]            wr_idx,
    input  hist_t                        wr_data,
    output pid_t                         cur_pid,
    output lvl_t                         cur_level,
    output logic [HIST_W*(NUM_LVL+1)-1:0] hist_flat
);
    // Current process and level: recognition first, then software writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_pid   <= '0;
            cur_level <= '0;
        end else if (rec_valid) begin
            cur_pid   <= '0;
            cur_level <= rec_lvl;
        end else if (wr_en) begin
            if (wr_idx == IDX_PID)   cur_pid   <= wr_data[PID_W-1:0];
            if (wr_idx == IDX_LEVEL) cur_level <= wr_data[LVL_W-1:0];
        end
    end

    assign hist_flat[HIST_W-1:0] = '0;

    // One saved-context register per level
    for (genvar l = 1; l <= NUM_LVL; l++) begin : g_ctx
        hist_t ctx_q;

        // Capture {0, old level, old pid} on entry to level l, else accept writes
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctx_q <= '0;
            end else if (rec_valid && rec_lvl == lvl_t'(l)) begin
                ctx_q <= {1'b0, cur_level, cur_pid};
            end else if (wr_en && wr_idx == IDX_CTX_BASE + REG_AW'(l)) begin
                ctx_q <= wr_data;
            end
        end

        assign hist_flat[l*HIST_W +: HIST_W] = ctx_q;
    end
endmodule

// File: rtl/irq_pid_tracker.sv
// Top of the interrupt-entry process ID tracker. Joins the configuration
// store, the entry detector and the context state, and provides the
// combinational register read path. Assumes ADDR_W >= 8.
module irq_pid_tracker
    import irq_pid_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic              fetch_is_data,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              reg_we,
    input  logic [4:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic [2:0]        cur_pid,
    output logic [2:0]        cur_level
);
    logic [NUM_LVL:1]              lvl_enable;
    logic [NUM_LVL*ADDR_W-1:0]     vec_flat;
    logic                          rec_valid;
    lvl_t                          rec_lvl;
    logic [HIST_W*(NUM_LVL+1)-1:0] hist_flat;
    pid_t                          pid_q;
    lvl_t                          lvl_q;

    irq_pid_cfg #(.ADDR_W(ADDR_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_we),
        .wr_idx     (reg_addr),
        .wr_data    (reg_wdata),
        .lvl_enable (lvl_enable),
        .vec_flat   (vec_flat)
    );

    irq_pid_match #(.ADDR_W(ADDR_W)) u_match (
        .fetch_valid   (fetch_valid),
        .fetch_is_data (fetch_is_data),
        .fetch_addr    (fetch_addr),
        .lvl_enable    (lvl_enable),
        .vec_flat      (vec_flat),
        .rec_valid     (rec_valid),
        .rec_lvl       (rec_lvl)
    );

    irq_pid_ctx u_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec_valid (rec_valid),
        .rec_lvl   (rec_lvl),
        .wr_en     (reg_we),
        .wr_idx    (reg_addr),
        .wr_data   (reg_wdata[HIST_W-1:0]),
        .cur_pid   (pid_q),
        .cur_level (lvl_q),
        .hist_flat (hist_flat)
    );

    assign cur_pid   = pid_q;
    assign cur_level = lvl_q;

    // Register read mux indexed by the word address
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == IDX_EN)    reg_rdata[NUM_LVL:0] = {lvl_enable, 1'b0};
        if (reg_addr == IDX_LEVEL) reg_rdata[LVL_W-1:0] = lvl_q;
        if (reg_addr == IDX_PID)   reg_rdata[PID_W-1:0] = pid_q;
        for (int l = 1; l <= NUM_LVL; l++) begin
            if (reg_addr == REG_AW'(l))
                reg_rdata = vec_flat[(l-1)*ADDR_W +: ADDR_W];
            if (reg_addr == IDX_CTX_BASE + REG_AW'(l))
                reg_rdata[HIST_W-1:0] = hist_flat[l*HIST_W +: HIST_W];
        end
    end
endmodule

// File: rtl/irq_pid_tracker_chk.sv
// Property checker for the tracker, attached by bind. Relates the detector
// output to the context state one cycle later.
module irq_pid_tracker_chk
    import irq_pid_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          fetch_valid,
    input logic                          fetch_is_data,
    input logic                          reg_we,
    input logic                          rec_valid,
    input lvl_t                          rec_lvl,
    input pid_t                          cur_pid,
    input lvl_t                          cur_level,
    input logic [HIST_W*(NUM_LVL+1)-1:0] hist_flat
);
    // R2: recognition forces process 0 and loads the recognised level
    p_enter_pid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> (cur_pid == '0) && (cur_level == $past(rec_lvl)));

    // R3: context register of the entered level holds the previous state
    p_ctx_save_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> hist_flat[$past(rec_lvl)*HIST_W +: HIST_W]
                      == {1'b0, $past(cur_level), $past(cur_pid)});

    // R4: without recognition or a write, no state moves
    p_no_rec_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rec_valid && !reg_we) |=> $stable(cur_pid) && $stable(cur_level)
                                    && $stable(hist_flat));

    // R5: data accesses never recognise
    p_data_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_is_data) |-> !rec_valid);

    // R6: a recognised level is never the "no interrupt" code
    p_level_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_lvl != '0));

    // R10: no fetch strobe means no recognition
    p_idle_no_rec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> !rec_valid);
endmodule

bind irq_pid_tracker irq_pid_tracker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_valid   (fetch_valid),
    .fetch_is_data (fetch_is_data),
    .reg_we        (reg_we),
    .rec_valid     (rec_valid),
    .rec_lvl       (rec_lvl),
    .cur_pid       (pid_q),
    .cur_level     (lvl_q),
    .hist_flat     (hist_flat)
);

// File: tb/irq_pid_tracker_tb_top.sv
// Self-checking bench: directed corner cases then seeded random traffic,
// compared against a bench-side model of the requirements.
module irq_pid_tracker_tb_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_valid = 1'b0;
    logic          fetch_is_data = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic          reg_we = 1'b0;
    logic [4:0]    reg_addr = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic [2:0]    cur_pid;
    logic [2:0]    cur_level;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // Bench model state
    logic [2:0]    m_pid;
    logic [2:0]    m_lvl;
    logic [6:0]    m_ctx [1:7];
    logic [7:1]    m_en;
    logic [AW-1:0] m_vec [1:7];

    irq_pid_tracker #(.ADDR_W(AW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_valid   (fetch_valid),
        .fetch_is_data (fetch_is_data),
        .fetch_addr    (fetch_addr),
        .reg_we        (reg_we),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .cur_pid       (cur_pid),
        .cur_level     (cur_level)
    );

    always #4ns clk = ~clk;

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] vaddr(input int l);
        return AW'(32'h0000_1000 + l * 32'h100);
    endfunction

    task automatic model_reset();
        m_pid = '0; m_lvl = '0; m_en = '0;
        for (int l = 1; l <= 7; l++) begin m_ctx[l] = '0; m_vec[l] = '0; end
    endtask

    // Next-state model: recognition from old state, then writes not overridden
    task automatic model_step(input logic fv, input logic fd, input logic [AW-1:0] fa,
                              input logic we, input logic [4:0] wa, input logic [AW-1:0] wd);
        bit         hit = 0;
        int         hl = 0;
        logic [2:0] opid = m_pid;
        logic [2:0] olvl = m_lvl;
        for (int l = 1; l <= 7; l++)
            if (fv && !fd && m_en[l] && fa == m_vec[l]) begin hit = 1; hl = l; end
        if (we) begin
            if (wa == 5'h00) m_en = wd[7:1];
            for (int l = 1; l <= 7; l++) begin
                if (wa == 5'(l)) m_vec[l] = wd;
                if (wa == 5'(16 + l) && !(hit && hl == l)) m_ctx[l] = wd[6:0];
            end
            if (!hit && wa == 5'h08) m_lvl = wd[2:0];
            if (!hit && wa == 5'h09) m_pid = wd[2:0];
        end
        if (hit) begin
            m_ctx[hl] = {1'b0, olvl, opid};
            m_pid = '0;
            m_lvl = 3'(hl);
        end
    endtask

    // One clock: drive at negedge, model after the edge, release at next negedge
    task automatic step(input logic fv, input logic fd, input logic [AW-1:0] fa,
                        input logic we, input logic [4:0] wa, input logic [AW-1:0] wd);
        fetch_valid = fv; fetch_is_data = fd; fetch_addr = fa;
        reg_we = we; reg_addr = wa; reg_wdata = wd;
        @(posedge clk);
        model_step(fv, fd, fa, we, wa, wd);
        @(negedge clk);
        fetch_valid = 1'b0; reg_we = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [AW-1:0] d);
        step(1'b0, 1'b0, '0, 1'b1, a, d);
    endtask

    task automatic fetch(input logic [AW-1:0] a, input logic is_data);
        step(1'b1, is_data, a, 1'b0, '0, '0);
    endtask

    task automatic rd(input logic [4:0] a, output logic [AW-1:0] d);
        reg_addr = a;
        #100ps;
        d = reg_rdata;
    endtask

    // Compare ports and every mapped register against the model
    task automatic compare_all(input string tag);
        logic [AW-1:0] d;
        chk({tag, " pid port"}, AW'(cur_pid), AW'(m_pid));
        chk({tag, " level port"}, AW'(cur_level), AW'(m_lvl));
        rd(5'h00, d); chk({tag, " enable reg"}, d, AW'({m_en, 1'b0}));
        rd(5'h08, d); chk({tag, " level reg"}, d, AW'(m_lvl));
        rd(5'h09, d); chk({tag, " pid reg"}, d, AW'(m_pid));
        for (int l = 1; l <= 7; l++) begin
            rd(5'(l), d);      chk({tag, $sformatf(" vec%0d", l)}, d, m_vec[l]);
            rd(5'(16 + l), d); chk({tag, $sformatf(" ctx%0d", l)}, d, AW'(m_ctx[l]));
        end
    endtask

    initial begin
        logic [AW-1:0] d;
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        compare_all("R1 reset");
        chk("R1 ctx7 zero", AW'(m_ctx[7]), '0);

        // R7: program vectors, enables and a running process, then read back
        for (int l = 1; l <= 7; l++) wr(5'(l), vaddr(l));
        wr(5'h00, 32'hFF);
        wr(5'h09, 32'h5);
        rd(5'h0A, d); chk("R7 unmapped reads 0", d, '0);
        rd(5'h00, d); chk("R7 enable bit0 reads 0", d, 32'hFE);
        compare_all("R7 readback");

        // R2/R3: enter level 3 from process 5
        fetch(vaddr(3), 1'b0);
        chk("R2 pid forced 0", AW'(cur_pid), 0);
        chk("R2 level 3", AW'(cur_level), 3);
        rd(5'h13, d); chk("R3 ctx3 = {0,0,5}", d, 32'h05);

        // R9: nested entry to level 5 saves level 3 and process 0
        fetch(vaddr(5), 1'b0);
        rd(5'h15, d); chk("R9 ctx5 = {0,3,0}", d, 32'h18);
        chk("R9 level 5", AW'(cur_level), 5);

        // R5: data access to an enabled vector does nothing
        wr(5'h09, 32'h2);
        fetch(vaddr(7), 1'b1);
        chk("R5 pid unchanged", AW'(cur_pid), 2);
        rd(5'h17, d); chk("R5 ctx7 unchanged", d, 0);

        // R10: address on the bus without strobe does nothing
        step(1'b0, 1'b0, vaddr(7), 1'b0, '0, '0);
        chk("R10 level unchanged", AW'(cur_level), 5);
        compare_all("R10 idle");

        // R4: disabled level 6 is ignored
        wr(5'h00, 32'hBE);
        fetch(vaddr(6), 1'b0);
        chk("R4 pid unchanged", AW'(cur_pid), 2);
        chk("R4 level unchanged", AW'(cur_level), 5);
        rd(5'h16, d); chk("R4 ctx6 unchanged", d, 0);

        // R6: vectors 2 and 4 alias; level 4 wins
        wr(5'h02, vaddr(4));
        wr(5'h08, 32'h1);
        fetch(vaddr(4), 1'b0);
        chk("R6 highest level wins", AW'(cur_level), 4);
        rd(5'h14, d); chk("R6 ctx4 = {0,1,2}", d, 32'h0A);
        rd(5'h12, d); chk("R6 ctx2 untouched", d, 0);

        // R8: collisions between recognition and bus writes
        wr(5'h09, 32'h3);
        step(1'b1, 1'b0, vaddr(1), 1'b1, 5'h09, 32'h6);
        chk("R8 pid write loses", AW'(cur_pid), 0);
        chk("R8 level 1", AW'(cur_level), 1);
        step(1'b1, 1'b0, vaddr(7), 1'b1, 5'h17, 32'h55);
        rd(5'h17, d); chk("R8 ctx7 from recognition", d, 32'h08);
        step(1'b1, 1'b0, vaddr(5), 1'b1, 5'h12, 32'h2A);
        rd(5'h12, d); chk("R8 other ctx write lands", d, 32'h2A);
        rd(5'h15, d); chk("R8 ctx5 = {0,7,0}", d, 32'h38);
        step(1'b1, 1'b0, vaddr(3), 1'b1, 5'h03, 32'h9999);
        chk("R8 old vector used", AW'(cur_level), 3);
        rd(5'h03, d); chk("R8 vector write lands", d, 32'h9999);
        compare_all("R8 collision");

        // Random traffic mixing fetches and writes
        for (int i = 0; i < 400; i++) begin
            int op = $urandom_range(0, 3);
            logic [4:0] wa;
            logic [AW-1:0] wd, fa;
            int sel = $urandom_range(0, 16);
            if (sel == 0) wa = 5'h00;
            else if (sel <= 7) wa = 5'(sel);
            else if (sel == 8) wa = 5'h08;
            else if (sel == 9) wa = 5'h09;
            else wa = 5'(16 + sel - 9);
            if (wa >= 5'h01 && wa <= 5'h07) wd = vaddr($urandom_range(1, 7));
            else wd = AW'($urandom);
            if ($urandom_range(0, 3) != 0) fa = vaddr($urandom_range(1, 7));
            else fa = AW'($urandom);
            case (op)
                0: wr(wa, wd);
                1: step(1'b1, 1'($urandom_range(0, 3) == 0), fa, 1'b0, '0, '0);
                2: step(1'b1, 1'($urandom_range(0, 3) == 0), fa, 1'b1, wa, wd);
                default: step(1'b0, 1'b0, fa, 1'b0, '0, '0);
            endcase
            compare_all("R2/R3/R8 random");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule